// File: doc/BRIEF.md
# Bus-Free Filter and Arbitration Starter

This block decides when a parallel SCSI bus has gone quiet, and starts arbitration when the host asks for it. A filter watches the synchronized, active-high BSY line continuously, whether or not arbitration is wanted. The bus counts as free only after BSY has been inactive for an unbroken 400 ns window. While the bus is free, SEL is inactive and the host's arbitrate control bit is set, the block asserts its BSY drive enable. It then times the 2.2 us arbitration delay and raises a flag that tells the host it may now sample the data bus to see which ID won.

The controller has three states. `ST_IDLE` drives nothing. `ST_DRIVE` drives BSY while the arbitration delay runs. `ST_SETTLED` keeps driving BSY with the delay-elapsed flag raised. The transitions are:
- `ST_IDLE -> ST_DRIVE` when the bus is free, SEL is low and the arbitrate bit is set, all in the same cycle.
- `ST_DRIVE -> ST_SETTLED` when the delay timer expires.
- `ST_DRIVE -> ST_IDLE` and `ST_SETTLED -> ST_IDLE` when the arbitrate bit is cleared.

Both windows become cycle counts by rounding up from the clock period parameter. The defaults are a 8000 ps period, giving 50 cycles for the bus-free window and 275 cycles for the arbitration delay.

Top module: `arb_start_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after reset is released, `bsy_oe`, `bus_free`, `arb_active` and `delay_done` are all low. Asserting reset during arbitration forces them all low at once.
- R2: `bus_free` goes high after exactly FREE_CYC consecutive clock edges with `bsy_in` low, where FREE_CYC = ceil(400000 ps / clock period). It stays high while `bsy_in` stays low.
- R3: Any clock edge that samples `bsy_in` high clears the quiet count. `bus_free` is low after that edge, and a partly completed window must start again from zero.
- R4: The bus-free filter runs while `arb_req` is low.
- R5: `bsy_oe` stays low if any one of these is true: `sel_in` is high, `bus_free` is low, or `arb_req` is low.
- R6: `bsy_oe` and `arb_active` go high on the first edge that samples `bus_free` high, `sel_in` low and `arb_req` high.
- R7: `delay_done` goes high exactly ARB_CYC edges after the edge that raised `bsy_oe`, where ARB_CYC = ceil(2200000 ps / clock period).
- R8: Once `delay_done` is high, it and `bsy_oe` stay high while `arb_req` stays high, whatever `sel_in` and `bsy_in` do.
- R9: An edge that samples `arb_req` low while arbitrating (in `ST_DRIVE` or `ST_SETTLED`) returns the block to `ST_IDLE`. `bsy_oe`, `arb_active` and `delay_done` are low after that edge.
- R10: If `arb_req` is sampled low on the same edge the delay timer expires, the release wins: the block goes to `ST_IDLE` and `delay_done` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bsy_in | input | 1 | Synchronized BSY line, high means asserted |
| sel_in | input | 1 | Synchronized SEL line, high means asserted |
| arb_req | input | 1 | Host arbitrate control bit |
| bsy_oe | output | 1 | Drive enable for BSY onto the bus |
| bus_free | output | 1 | BSY has been quiet for the full window |
| arb_active | output | 1 | Arbitration in progress |
| delay_done | output | 1 | Arbitration delay has elapsed; the data bus may be sampled |

## Verification
The critical collision is a host release that lands on the same edge the arbitration timer expires. Both the move to `ST_SETTLED` and the move to `ST_IDLE` are legal on that edge. The bench starts arbitration, holds `arb_req` for ARB_CYC-1 edges, and then drops it so that the next edge is both the expiry edge and the release edge. It then judges that `bsy_oe` and `delay_done` are low after that edge and that `delay_done` stays low for several cycles afterwards. A second coincidence, a one-cycle BSY pulse on the last cycle of a quiet window, is driven the same way and must leave `bus_free` low for a full new window.

// File: rtl/arbst_pkg.sv
package arbst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_SETTLED = 2'd2
    } arb_state_e;

    // Round a time window up to whole clock cycles.
    function automatic int unsigned win_to_cycles(input int unsigned win_ps,
                                                  input int unsigned period_ps);
        return (win_ps + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/bus_free_filter.sv
module bus_free_filter #(
    parameter int unsigned QUIET_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsy_in,
    output logic bus_free
);
    localparam int unsigned CW = $clog2(QUIET_CYC + 1);

    logic [CW-1:0] quiet_cnt;
    logic          full;

    assign full = (quiet_cnt == CW'(QUIET_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (bsy_in)
            quiet_cnt <= '0;
        else if (!full)
            quiet_cnt <= quiet_cnt + CW'(1);
    end

    assign bus_free = full;

    // R3
    bsy_clears_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_in |=> !bus_free);

    // R2
    free_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(!bsy_in));

endmodule

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
    parameter int unsigned DELAY_CYC = 275
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] elapsed;

    assign expired = run && (elapsed == CW'(DELAY_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!run)
            elapsed <= '0;
        else if (!expired)
            elapsed <= elapsed + CW'(1);
    end

    // R7
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (elapsed == '0));

endmodule

// File: rtl/arb_start_ctrl.sv
module arb_start_ctrl
    import arbst_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS  = 8000,
    parameter int unsigned FREE_WINDOW_PS = 400000,
    parameter int unsigned ARB_WINDOW_PS  = 2200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsy_in,
    input  logic sel_in,
    input  logic arb_req,
    output logic bsy_oe,
    output logic bus_free,
    output logic arb_active,
    output logic delay_done
);
    localparam int unsigned FREE_CYC = win_to_cycles(FREE_WINDOW_PS, CLK_PERIOD_PS);
    localparam int unsigned ARB_CYC  = win_to_cycles(ARB_WINDOW_PS, CLK_PERIOD_PS);

    arb_state_e state, nxt;
    logic       free_q;
    logic       timer_run;
    logic       timer_exp;
    logic       start_ok;

    bus_free_filter #(.QUIET_CYC(FREE_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bsy_in   (bsy_in),
        .bus_free (free_q)
    );

    assign timer_run = (state == ST_DRIVE);

    arb_delay_timer #(.DELAY_CYC(ARB_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (timer_exp)
    );

    assign start_ok = arb_req && free_q && !sel_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_ok) nxt = ST_DRIVE;
            ST_DRIVE:   if (!arb_req) nxt = ST_IDLE;
                        else if (timer_exp) nxt = ST_SETTLED;
            ST_SETTLED: if (!arb_req) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bsy_oe     = 1'b0;
        arb_active = 1'b0;
        delay_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DRIVE: begin
                bsy_oe     = 1'b1;
                arb_active = 1'b1;
            end
            ST_SETTLED: begin
                bsy_oe     = 1'b1;
                arb_active = 1'b1;
                delay_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_free = free_q;

    // R5
    start_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe) |-> $past(arb_req && bus_free && !sel_in));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_req |=> !bsy_oe);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_done && arb_req) |=> delay_done);

    // R7
    done_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delay_done) |-> $past(bsy_oe && arb_req));

endmodule

// File: tb/sim_arb_start_ctrl.sv
`timescale 1ns/1ps
module sim_arb_start_ctrl;

    localparam int PERIOD_PS = 8000;
    localparam int FC = (400000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int AC = (2200000 + PERIOD_PS - 1) / PERIOD_PS;

    typedef struct packed {
        logic        ext;
        logic        sel;
        logic        arb;
        logic [15:0] cyc;
        logic        free;
        logic        oe;
        logic        done;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 16'd4,        1'b0, 1'b0, 1'b0, 4'd4},  // R4 bus held busy
        '{1'b0, 1'b0, 1'b0, 16'(FC - 1),  1'b0, 1'b0, 1'b0, 4'd2},  // R2 one short of window
        '{1'b0, 1'b0, 1'b0, 16'd1,        1'b1, 1'b0, 1'b0, 4'd2},  // R2 window complete
        '{1'b1, 1'b0, 1'b0, 16'd1,        1'b0, 1'b0, 1'b0, 4'd3},  // R3 BSY clears flag
        '{1'b0, 1'b0, 1'b0, 16'(FC - 1),  1'b0, 1'b0, 1'b0, 4'd3},  // R3 partial window
        '{1'b1, 1'b0, 1'b0, 16'd1,        1'b0, 1'b0, 1'b0, 4'd3},  // R3 pulse at last cycle
        '{1'b0, 1'b0, 1'b0, 16'(FC - 1),  1'b0, 1'b0, 1'b0, 4'd3},  // R3 restarted from zero
        '{1'b0, 1'b0, 1'b0, 16'd1,        1'b1, 1'b0, 1'b0, 4'd5},  // R5 free but arb low
        '{1'b0, 1'b1, 1'b1, 16'd3,        1'b1, 1'b0, 1'b0, 4'd5},  // R5 SEL blocks start
        '{1'b0, 1'b0, 1'b1, 16'd1,        1'b1, 1'b1, 1'b0, 4'd6},  // R6 start
        '{1'b0, 1'b0, 1'b1, 16'd1,        1'b0, 1'b1, 1'b0, 4'd6},  // R6 own BSY seen
        '{1'b0, 1'b0, 1'b1, 16'(AC - 2),  1'b0, 1'b1, 1'b0, 4'd7},  // R7 one short of delay
        '{1'b0, 1'b0, 1'b1, 16'd1,        1'b0, 1'b1, 1'b1, 4'd7},  // R7 delay elapsed
        '{1'b1, 1'b1, 1'b1, 16'd20,       1'b0, 1'b1, 1'b1, 4'd8},  // R8 held despite SEL
        '{1'b0, 1'b0, 1'b0, 16'd1,        1'b0, 1'b0, 1'b0, 4'd9},  // R9 release from settled
        '{1'b0, 1'b0, 1'b0, 16'(FC),      1'b1, 1'b0, 1'b0, 4'd4},  // R4 filter counts idle
        '{1'b1, 1'b0, 1'b0, 16'd2,        1'b0, 1'b0, 1'b0, 4'd3},  // R3 busy again
        '{1'b0, 1'b0, 1'b1, 16'(FC),      1'b1, 1'b0, 1'b0, 4'd5},  // R5 not free blocks
        '{1'b0, 1'b0, 1'b1, 16'd1,        1'b1, 1'b1, 1'b0, 4'd6},  // R6 start after free
        '{1'b0, 1'b0, 1'b1, 16'd100,      1'b0, 1'b1, 1'b0, 4'd7},  // R7 mid delay
        '{1'b0, 1'b0, 1'b0, 16'd1,        1'b0, 1'b0, 1'b0, 4'd9},  // R9 release mid delay
        '{1'b0, 1'b0, 1'b0, 16'(FC),      1'b1, 1'b0, 1'b0, 4'd2},  // R2 free again
        '{1'b0, 1'b0, 1'b1, 16'd1,        1'b1, 1'b1, 1'b0, 4'd6},  // R6 third start
        '{1'b0, 1'b0, 1'b1, 16'(AC - 1),  1'b0, 1'b1, 1'b0, 4'd10}, // R10 edge before expiry
        '{1'b0, 1'b0, 1'b0, 16'd1,        1'b0, 1'b0, 1'b0, 4'd10}, // R10 release at expiry
        '{1'b0, 1'b0, 1'b0, 16'd5,        1'b0, 1'b0, 1'b0, 4'd10}  // R10 flag never rose
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_bsy = 1'b0;
    logic sel_in = 1'b0;
    logic arb_req = 1'b0;
    logic bsy_in;
    logic bsy_oe, bus_free, arb_active, delay_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign bsy_in = ext_bsy | bsy_oe;

    arb_start_ctrl #(.CLK_PERIOD_PS(PERIOD_PS)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bsy_in     (bsy_in),
        .sel_in     (sel_in),
        .arb_req    (arb_req),
        .bsy_oe     (bsy_oe),
        .bus_free   (bus_free),
        .arb_active (arb_active),
        .delay_done (delay_done)
    );

    task automatic check(input int req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input int req, input logic f, input logic o, input logic d);
        check(req, "bus_free", bus_free, f);
        check(req, "bsy_oe", bsy_oe, o);
        check(req, "arb_active", arb_active, o);
        check(req, "delay_done", delay_done, d);
    endtask

    initial begin
        // R1 reset state
        ext_bsy = 1'b1;
        repeat (3) @(negedge clk);
        check_all(1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            ext_bsy = VECS[i].ext;
            sel_in  = VECS[i].sel;
            arb_req = VECS[i].arb;
            repeat (int'(VECS[i].cyc)) @(negedge clk);
            check_all(int'(VECS[i].req), VECS[i].free, VECS[i].oe, VECS[i].done);
        end

        // R1 reset during arbitration
        ext_bsy = 1'b0; sel_in = 1'b0; arb_req = 1'b1;
        repeat (FC + 2) @(negedge clk);
        check(1, "bsy_oe before reset", bsy_oe, 1'b1);
        rst_n = 1'b0;
        #1;
        check_all(1, 1'b0, 1'b0, 1'b0);
        arb_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1, 1'b0, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule